// File: doc/BRIEF.md
# Two-Phase Instruction Sequencer

This block is the control and program-counter path of a small 15-bit load/store processor. It repeats a fixed two-cycle rhythm. In the first cycle it places the program counter on the memory address bus and raises the read strobe. The returned word is captured in the instruction buffer. In the second cycle it carries out the instruction. It writes immediates, loaded words or return addresses through the register-file write port. It drives the memory bus for loads and stores, and it selects the next program counter value.

The block reads two register-file ports, combinationally and selected straight from instruction fields, and the flag vector from the flags unit. Arithmetic and logic opcodes and the interrupt save/restore machinery sit outside the block. The only part of the interrupt path it handles is a program-counter load request. When that request is present in the second cycle, it overrides the normal next-PC choice. In the register file, memory and bus descriptions, every opcode not listed below is treated as a no-operation.

Top module: `cpu_seq_core`

## Requirements
- R1: A synchronous active-low reset sets the PC to 0, the instruction buffer to 0 and the phase to fetch. The first cycle after reset is a fetch from address 0.
- R2: The phases alternate strictly: fetch, execute, fetch, and so on. During fetch, `mem_addr` equals the PC, `mem_re`=1, `mem_we`=0 and `rf_wr_en`=0, and `exec_phase`=0. `exec_phase`=1 during execute.
- R3: The PC changes only at the clock edge that ends an execute cycle. For opcode 5'h00, and for any instruction that does not redirect the PC, it advances by one.
- R4: In instruction bits, the opcode is [14:10], field F1 is [9:7] and field F2 is [6:4]. Opcode 5'h01 writes {old[14:8],0,imm7} to register F1. Opcode 5'h02 writes {old[14:8],1,imm7} to register F1. Opcode 5'h03 writes {imm7,old[7:0]} to register F1. In all three, imm7 is bits [6:0].
- R5: Opcode 5'h04 (load) reads memory at register F2 plus the sign-extended bits [3:0] with `mem_re`=1. It writes `mem_rdata` to register F1.
- R6: Opcode 5'h05 (store) drives the same address, raises `mem_we` and places register F1 on `mem_wdata`. It makes no register write.
- R7: Opcode 5'h10 (branch) tests flag bit F1 of `flags_in`. When that bit is 1, the next PC is the PC plus the sign-extended bits [6:0]. When it is 0, the next PC is PC+1.
- R8: Flag position ALWAYS_FLAG_IDX counts as set whatever `flags_in` carries, so a branch on it is always taken.
- R9: Opcode 5'h11 loads the PC from register F1. Opcode 5'h12 loads the PC from register F2 and writes the old PC+1 into register F1.
- R10: `mem_re` and `mem_we` are never high together. Both are low in an execute cycle of any instruction other than a load or a store.
- R11: Every opcode other than 5'h00–5'h05 and 5'h10–5'h12 makes no register write, raises no memory strobe and advances the PC by one.
- R12: `pc_load_req` high in an execute cycle makes the next PC equal `pc_load_value`, overriding all instruction flow. `pc_load_req` is ignored in a fetch cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 15 | Memory address |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 15 | Store data |
| mem_rdata | input | 15 | Word returned by memory, combinational |
| rf_rd_a_sel | output | 3 | Register read port A select (field F1) |
| rf_rd_a_data | input | 15 | Register read port A data |
| rf_rd_b_sel | output | 3 | Register read port B select (field F2) |
| rf_rd_b_data | input | 15 | Register read port B data |
| rf_wr_en | output | 1 | Register write enable |
| rf_wr_sel | output | 3 | Register write select |
| rf_wr_data | output | 15 | Register write data |
| flags_in | input | 8 | Flag vector from the flags unit |
| pc_load_req | input | 1 | Program-counter load request |
| pc_load_value | input | 15 | Value loaded by the request |
| pc_out | output | 15 | Current program counter |
| ib_out | output | 15 | Current instruction buffer |
| exec_phase | output | 1 | 1 in the execute cycle |

## Verification
The bench builds the sequencer with ALWAYS_FLAG_IDX set to 5 instead of the default 0. This lets a branch on flag 0 be taken or not taken by the input alone, and places the forced flag in the middle of the vector, so a wrong mask or index shows up. Its memory model keeps 256 words and aliases the upper address bits. As a result, jumps and subroutine calls can move the PC to wide values such as 15'h1ABC. From there, the extreme branch offsets of -64 and +60 and negative load/store offsets reach addresses well away from zero.

// File: rtl/cpu_seq_pkg.sv
// Shared widths, instruction field positions, opcodes and decoded control
// bundle for the two-phase sequencer. Assumes a fixed 15-bit word format.
package cpu_seq_pkg;
    localparam int XLEN   = 15;
    localparam int OP_W   = 5;
    localparam int REG_W  = 3;
    localparam int FLAG_W = 1 << REG_W;
    localparam int IMM_W  = 7;
    localparam int BOFF_W = 7;
    localparam int MOFF_W = 4;

    localparam int OP_LSB = XLEN - OP_W;
    localparam int F1_LSB = OP_LSB - REG_W;
    localparam int F2_LSB = F1_LSB - REG_W;

    localparam logic [OP_W-1:0] OPC_NOP  = 5'h00;
    localparam logic [OP_W-1:0] OPC_LIL0 = 5'h01;
    localparam logic [OP_W-1:0] OPC_LIL1 = 5'h02;
    localparam logic [OP_W-1:0] OPC_LIH  = 5'h03;
    localparam logic [OP_W-1:0] OPC_LD   = 5'h04;
    localparam logic [OP_W-1:0] OPC_ST   = 5'h05;
    localparam logic [OP_W-1:0] OPC_BR   = 5'h10;
    localparam logic [OP_W-1:0] OPC_JMP  = 5'h11;
    localparam logic [OP_W-1:0] OPC_JSR  = 5'h12;

    typedef enum logic [2:0] {
        WR_NONE,
        WR_IMM_LO0,
        WR_IMM_LO1,
        WR_IMM_HI,
        WR_MEM,
        WR_LINK
    } wr_src_e;

    typedef struct packed {
        logic    is_ld;
        logic    is_st;
        logic    is_br;
        logic    is_jmp;
        logic    is_jsr;
        wr_src_e wsrc;
    } seq_ctrl_t;
endpackage

// File: rtl/cpu_seq_phase.sv
// Phase flip-flop: fetch (0) and execute (1) alternate every clock.
// Assumes a synchronous active-low reset that selects fetch.
module cpu_seq_phase (
    input  logic clk,
    input  logic rst_n,
    output logic exec_o
);
    logic exec_q;

    // Toggle phase each cycle, fetch after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) exec_q <= 1'b0;
        else        exec_q <= ~exec_q;
    end

    assign exec_o = exec_q;

    assert_exec_to_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        exec_q |=> !exec_q);
    assert_fetch_to_exec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_q |=> exec_q);
endmodule

// File: rtl/cpu_seq_decode.sv
// Combinational decoder from the instruction buffer to the control bundle.
// Assumes unlisted opcodes are no-operations (all controls inactive).
module cpu_seq_decode
    import cpu_seq_pkg::*;
(
    input  logic [XLEN-1:0] ib_i,
    output seq_ctrl_t       ctrl_o
);
    logic [OP_W-1:0] opc;
    assign opc = ib_i[OP_LSB +: OP_W];

    // Map the opcode onto the control bundle.
    always_comb begin
        ctrl_o = '{is_ld: 1'b0, is_st: 1'b0, is_br: 1'b0, is_jmp: 1'b0,
                   is_jsr: 1'b0, wsrc: WR_NONE};
        case (opc)
            OPC_LIL0: ctrl_o.wsrc = WR_IMM_LO0;
            OPC_LIL1: ctrl_o.wsrc = WR_IMM_LO1;
            OPC_LIH:  ctrl_o.wsrc = WR_IMM_HI;
            OPC_LD:   begin ctrl_o.is_ld  = 1'b1; ctrl_o.wsrc = WR_MEM;  end
            OPC_ST:   ctrl_o.is_st  = 1'b1;
            OPC_BR:   ctrl_o.is_br  = 1'b1;
            OPC_JMP:  ctrl_o.is_jmp = 1'b1;
            OPC_JSR:  begin ctrl_o.is_jsr = 1'b1; ctrl_o.wsrc = WR_LINK; end
            default:  ctrl_o.wsrc = WR_NONE;
        endcase
    end
endmodule

// File: rtl/cpu_seq_pc_unit.sv
// Program counter and next-PC selection. The PC only moves at the end of an
// execute cycle; an external load request outranks all instruction flow.
// Assumes flags_i has one bit per value of the branch flag field.
module cpu_seq_pc_unit
    import cpu_seq_pkg::*;
#(
    parameter int ALWAYS_FLAG_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec_i,
    input  logic              is_br_i,
    input  logic              is_jmp_i,
    input  logic              is_jsr_i,
    input  logic [BOFF_W-1:0] br_off_i,
    input  logic [REG_W-1:0]  flag_sel_i,
    input  logic [FLAG_W-1:0] flags_i,
    input  logic [XLEN-1:0]   jmp_tgt_i,
    input  logic [XLEN-1:0]   jsr_tgt_i,
    input  logic              load_req_i,
    input  logic [XLEN-1:0]   load_val_i,
    output logic [XLEN-1:0]   pc_o,
    output logic [XLEN-1:0]   pc_inc_o
);
    localparam logic [FLAG_W-1:0] ALWAYS_MASK = FLAG_W'(1) << ALWAYS_FLAG_IDX;
    localparam logic [REG_W-1:0]  ALWAYS_SEL  = REG_W'(ALWAYS_FLAG_IDX);

    logic [XLEN-1:0]   pc_q, pc_nxt, br_tgt;
    logic [FLAG_W-1:0] eff_flags;
    logic              taken;

    assign eff_flags = flags_i | ALWAYS_MASK;
    assign taken     = is_br_i & eff_flags[flag_sel_i];
    assign pc_inc_o  = pc_q + XLEN'(1);
    assign br_tgt    = pc_q + {{(XLEN-BOFF_W){br_off_i[BOFF_W-1]}}, br_off_i};

    // Choose the PC that follows the current execute cycle.
    always_comb begin
        if (load_req_i)    pc_nxt = load_val_i;
        else if (taken)    pc_nxt = br_tgt;
        else if (is_jmp_i) pc_nxt = jmp_tgt_i;
        else if (is_jsr_i) pc_nxt = jsr_tgt_i;
        else               pc_nxt = pc_inc_o;
    end

    // Update the PC only at the end of execute.
    always_ff @(posedge clk) begin
        if (!rst_n)      pc_q <= '0;
        else if (exec_i) pc_q <= pc_nxt;
    end

    assign pc_o = pc_q;

    assert_pc_hold_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_i |=> pc_q == $past(pc_q));
    assert_pc_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        exec_i && !load_req_i && !is_br_i && !is_jmp_i && !is_jsr_i
        |=> pc_q == $past(pc_q) + XLEN'(1));
    assert_br_not_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
        exec_i && !load_req_i && is_br_i && !flags_i[flag_sel_i] && flag_sel_i != ALWAYS_SEL
        |=> pc_q == $past(pc_q) + XLEN'(1));
    assert_always_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        exec_i && !load_req_i && is_br_i && flag_sel_i == ALWAYS_SEL
        |=> pc_q != $past(pc_q) + XLEN'(1) || br_off_i == BOFF_W'(1));
    assert_load_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
        exec_i && load_req_i |=> pc_q == $past(load_val_i));
endmodule

// File: rtl/cpu_seq_mem_port.sv
// Memory bus driver: PC with a read strobe in fetch, base plus signed offset
// for loads and stores in execute, both strobes low otherwise.
module cpu_seq_mem_port
    import cpu_seq_pkg::*;
(
    input  logic              exec_i,
    input  logic              is_ld_i,
    input  logic              is_st_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [XLEN-1:0]   base_i,
    input  logic [MOFF_W-1:0] off_i,
    input  logic [XLEN-1:0]   src_i,
    output logic [XLEN-1:0]   addr_o,
    output logic              re_o,
    output logic              we_o,
    output logic [XLEN-1:0]   wdata_o
);
    logic [XLEN-1:0] eff_addr;
    assign eff_addr = base_i + {{(XLEN-MOFF_W){off_i[MOFF_W-1]}}, off_i};

    // Select address and strobes for the current phase.
    always_comb begin
        if (!exec_i) begin
            addr_o = pc_i;
            re_o   = 1'b1;
            we_o   = 1'b0;
        end else begin
            addr_o = eff_addr;
            re_o   = is_ld_i;
            we_o   = is_st_i;
        end
    end

    assign wdata_o = src_i;
endmodule

// File: rtl/cpu_seq_core.sv
// Top of the two-phase sequencer: instruction buffer, decode, PC unit,
// memory port and register-file write composition. Assumes combinational
// memory and register-file reads.
module cpu_seq_core
    import cpu_seq_pkg::*;
#(
    parameter int ALWAYS_FLAG_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [XLEN-1:0]   mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [XLEN-1:0]   mem_wdata,
    input  logic [XLEN-1:0]   mem_rdata,
    output logic [REG_W-1:0]  rf_rd_a_sel,
    input  logic [XLEN-1:0]   rf_rd_a_data,
    output logic [REG_W-1:0]  rf_rd_b_sel,
    input  logic [XLEN-1:0]   rf_rd_b_data,
    output logic              rf_wr_en,
    output logic [REG_W-1:0]  rf_wr_sel,
    output logic [XLEN-1:0]   rf_wr_data,
    input  logic [FLAG_W-1:0] flags_in,
    input  logic              pc_load_req,
    input  logic [XLEN-1:0]   pc_load_value,
    output logic [XLEN-1:0]   pc_out,
    output logic              exec_phase
    ,
    output logic [XLEN-1:0]   ib_out
);
    logic [XLEN-1:0]  ib_q, pc, pc_inc;
    logic             exec;
    seq_ctrl_t        ctrl;
    logic [IMM_W-1:0] imm;

    // Capture the fetched word at the end of fetch.
    always_ff @(posedge clk) begin
        if (!rst_n)    ib_q <= '0;
        else if (!exec) ib_q <= mem_rdata;
    end

    cpu_seq_phase u_phase (.clk(clk), .rst_n(rst_n), .exec_o(exec));

    cpu_seq_decode u_dec (.ib_i(ib_q), .ctrl_o(ctrl));

    cpu_seq_pc_unit #(.ALWAYS_FLAG_IDX(ALWAYS_FLAG_IDX)) u_pc (
        .clk(clk), .rst_n(rst_n), .exec_i(exec),
        .is_br_i(ctrl.is_br), .is_jmp_i(ctrl.is_jmp), .is_jsr_i(ctrl.is_jsr),
        .br_off_i(ib_q[BOFF_W-1:0]), .flag_sel_i(ib_q[F1_LSB +: REG_W]),
        .flags_i(flags_in), .jmp_tgt_i(rf_rd_a_data), .jsr_tgt_i(rf_rd_b_data),
        .load_req_i(pc_load_req), .load_val_i(pc_load_value),
        .pc_o(pc), .pc_inc_o(pc_inc));

    cpu_seq_mem_port u_mem (
        .exec_i(exec), .is_ld_i(ctrl.is_ld), .is_st_i(ctrl.is_st),
        .pc_i(pc), .base_i(rf_rd_b_data), .off_i(ib_q[MOFF_W-1:0]),
        .src_i(rf_rd_a_data), .addr_o(mem_addr), .re_o(mem_re),
        .we_o(mem_we), .wdata_o(mem_wdata));

    assign rf_rd_a_sel = ib_q[F1_LSB +: REG_W];
    assign rf_rd_b_sel = ib_q[F2_LSB +: REG_W];
    assign rf_wr_sel   = rf_rd_a_sel;
    assign rf_wr_en    = exec && (ctrl.wsrc != WR_NONE);
    assign imm         = ib_q[IMM_W-1:0];

    // Compose the register write value for the decoded source.
    always_comb begin
        case (ctrl.wsrc)
            WR_IMM_LO0: rf_wr_data = {rf_rd_a_data[XLEN-1:IMM_W+1], 1'b0, imm};
            WR_IMM_LO1: rf_wr_data = {rf_rd_a_data[XLEN-1:IMM_W+1], 1'b1, imm};
            WR_IMM_HI:  rf_wr_data = {imm, rf_rd_a_data[XLEN-IMM_W-1:0]};
            WR_MEM:     rf_wr_data = mem_rdata;
            WR_LINK:    rf_wr_data = pc_inc;
            default:    rf_wr_data = '0;
        endcase
    end

    assign pc_out     = pc;
    assign ib_out     = ib_q;
    assign exec_phase = exec;

    assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));
    assert_quiet_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
        exec && !ctrl.is_ld && !ctrl.is_st |-> !mem_re && !mem_we);
    assert_fetch_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !exec |-> mem_re && !mem_we && !rf_wr_en && mem_addr == pc);
    assert_decode_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctrl.is_ld, ctrl.is_st, ctrl.is_br, ctrl.is_jmp, ctrl.is_jsr}));
    assert_load_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        exec && ctrl.is_ld |-> rf_wr_en && rf_wr_data == mem_rdata);
endmodule

// File: tb/tb_cpu_seq_core.sv
`timescale 1ns/1ps
module tb_cpu_seq_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_re, mem_we;
    logic [2:0]  rf_rd_a_sel, rf_rd_b_sel, rf_wr_sel;
    logic [14:0] rf_rd_a_data, rf_rd_b_data, rf_wr_data;
    logic        rf_wr_en;
    logic [7:0]  flags_in = 8'h00;
    logic        pc_load_req = 1'b0;
    logic [14:0] pc_load_value = '0;
    logic [14:0] pc_out, ib_out;
    logic        exec_phase;

    int checks = 0;
    int errors = 0;
    int both_strobes = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cpu_seq_core #(.ALWAYS_FLAG_IDX(5)) dut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_re(mem_re),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .rf_rd_a_sel(rf_rd_a_sel), .rf_rd_a_data(rf_rd_a_data),
        .rf_rd_b_sel(rf_rd_b_sel), .rf_rd_b_data(rf_rd_b_data),
        .rf_wr_en(rf_wr_en), .rf_wr_sel(rf_wr_sel), .rf_wr_data(rf_wr_data),
        .flags_in(flags_in), .pc_load_req(pc_load_req),
        .pc_load_value(pc_load_value), .pc_out(pc_out),
        .exec_phase(exec_phase), .ib_out(ib_out));

    // Memory model: 256 words, upper address bits alias.
    logic [14:0] mem [0:255];
    logic        ld_we = 1'b0;
    logic [7:0]  ld_addr = '0;
    logic [14:0] ld_data = '0;
    always_ff @(posedge clk) begin
        if (ld_we)       mem[ld_addr] <= ld_data;
        else if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    end
    assign mem_rdata = mem[mem_addr[7:0]];

    // Register file model, preset while in reset.
    logic [14:0] regs [0:7];
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs[0] <= 15'h0000; regs[1] <= 15'h0040;
            regs[2] <= 15'h1234; regs[3] <= 15'h7F00;
            regs[4] <= 15'h0005; regs[5] <= 15'h0080;
            regs[6] <= 15'h2AAA; regs[7] <= 15'h0030;
        end else if (rf_wr_en) begin
            regs[rf_wr_sel] <= rf_wr_data;
        end
    end
    assign rf_rd_a_data = regs[rf_rd_a_sel];
    assign rf_rd_b_data = regs[rf_rd_b_sel];

    // R10 monitor: both strobes high is never legal.
    always @(negedge clk) if (rst_n && mem_re && mem_we) both_strobes++;

    // Vector: pc, instr, flags, next pc, re, we, addr, wen, wsel, data (89 bits)
    localparam int NV = 18;
    localparam logic [88:0] VEC [NV] = '{
        {15'h0000, 15'h0000, 8'h00, 15'h0001, 1'b0, 1'b0, 15'h0000, 1'b0, 3'd0, 15'h0000},
        {15'h0001, 15'h0555, 8'h00, 15'h0002, 1'b0, 1'b0, 15'h0000, 1'b1, 3'd2, 15'h1255},
        {15'h0002, 15'h0981, 8'h00, 15'h0003, 1'b0, 1'b0, 15'h0000, 1'b1, 3'd3, 15'h7F81},
        {15'h0003, 15'h0E7F, 8'h00, 15'h0004, 1'b0, 1'b0, 15'h0000, 1'b1, 3'd4, 15'h7F05},
        {15'h0004, 15'h131F, 8'h00, 15'h0005, 1'b1, 1'b0, 15'h003F, 1'b1, 3'd6, 15'h1ABC},
        {15'h0005, 15'h1557, 8'h00, 15'h0006, 1'b0, 1'b1, 15'h0087, 1'b0, 3'd0, 15'h1255},
        {15'h0006, 15'h1057, 8'h00, 15'h0007, 1'b1, 1'b0, 15'h0087, 1'b1, 3'd0, 15'h1255},
        {15'h0007, 15'h4185, 8'h08, 15'h000C, 1'b0, 1'b0, 15'h0000, 1'b0, 3'd0, 15'h0000},
        {15'h000C, 15'h4185, 8'hF7, 15'h000D, 1'b0, 1'b0, 15'h0000, 1'b0, 3'd0, 15'h0000},
        {15'h000D, 15'h42FD, 8'h00, 15'h000A, 1'b0, 1'b0, 15'h0000, 1'b0, 3'd0, 15'h0000},
        {15'h000A, 15'h4014, 8'hFE, 15'h000B, 1'b0, 1'b0, 15'h0000, 1'b0, 3'd0, 15'h0000},
        {15'h000B, 15'h4780, 8'h00, 15'h0030, 1'b0, 1'b0, 15'h0000, 1'b0, 3'd0, 15'h0000},
        {15'h0030, 15'h48E0, 8'h00, 15'h1ABC, 1'b0, 1'b0, 15'h0000, 1'b1, 3'd1, 15'h0031},
        {15'h1ABC, 15'h42C0, 8'h00, 15'h1A7C, 1'b0, 1'b0, 15'h0000, 1'b0, 3'd0, 15'h0000},
        {15'h1A7C, 15'h413C, 8'h04, 15'h1AB8, 1'b0, 1'b0, 15'h0000, 1'b0, 3'd0, 15'h0000},
        {15'h1AB8, 15'h1488, 8'h00, 15'h1AB9, 1'b0, 1'b1, 15'h124D, 1'b0, 3'd0, 15'h0031},
        {15'h1AB9, 15'h7DAA, 8'hFF, 15'h1ABA, 1'b0, 1'b0, 15'h0000, 1'b0, 3'd0, 15'h0000},
        {15'h1ABA, 15'h1108, 8'h00, 15'h1ABB, 1'b1, 1'b0, 15'h124D, 1'b1, 3'd2, 15'h0031}
    };

    function automatic string tag_of(input logic [14:0] ins);
        case (ins[14:10])
            5'h00:               return "R3";
            5'h01, 5'h02, 5'h03: return "R4";
            5'h04:               return "R5";
            5'h05:               return "R6";
            5'h10:               return (ins[9:7] == 3'd5) ? "R8" : "R7";
            5'h11, 5'h12:        return "R9";
            default:             return "R11";
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic load(input logic [7:0] a, input logic [14:0] d);
        ld_we = 1'b1; ld_addr = a; ld_data = d;
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R2 watchdog: actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < 256; a++) load(8'(a), 15'h0000);
        for (int i = 0; i < NV; i++) load(VEC[i][81:74], VEC[i][73:59]);
        load(8'h3F, 15'h1ABC);
        ld_we = 1'b0;
        rst_n = 1'b1;

        // R1: reset state, before the first active edge.
        chk("R1", "pc", 32'(pc_out), 32'h0);
        chk("R1", "ib", 32'(ib_out), 32'h0);
        chk("R1", "phase", 32'(exec_phase), 32'h0);
        chk("R1", "addr", 32'(mem_addr), 32'h0);
        chk("R1", "wr_en", 32'(rf_wr_en), 32'h0);

        // Table walk: one fetch and one execute per vector.
        for (int i = 0; i < NV; i++) begin
            string t;
            t = tag_of(VEC[i][73:59]);
            flags_in = VEC[i][58:51];
            chk("R2", "fetch phase", 32'(exec_phase), 32'h0);
            chk("R2", "fetch addr", 32'(mem_addr), 32'(VEC[i][88:74]));
            chk("R2", "fetch re/we", 32'({mem_re, mem_we}), 32'h2);
            chk("R2", "fetch wr_en", 32'(rf_wr_en), 32'h0);
            @(posedge clk); @(negedge clk);
            chk("R2", "exec phase", 32'(exec_phase), 32'h1);
            chk("R3", "pc held in exec", 32'(pc_out), 32'(VEC[i][88:74]));
            chk(t, "re", 32'(mem_re), 32'(VEC[i][35]));
            chk(t, "we", 32'(mem_we), 32'(VEC[i][34]));
            if (VEC[i][35] || VEC[i][34]) chk(t, "mem addr", 32'(mem_addr), 32'(VEC[i][33:19]));
            if (VEC[i][34]) chk(t, "wdata", 32'(mem_wdata), 32'(VEC[i][14:0]));
            chk(t, "wr_en", 32'(rf_wr_en), 32'(VEC[i][18]));
            if (VEC[i][18]) begin
                chk(t, "wr_sel", 32'(rf_wr_sel), 32'(VEC[i][17:15]));
                chk(t, "wr_data", 32'(rf_wr_data), 32'(VEC[i][14:0]));
            end
            @(posedge clk); @(negedge clk);
            chk(t, "next pc", 32'(pc_out), 32'(VEC[i][50:36]));
        end

        // R12: load request in fetch ignored, in execute takes effect.
        pc_load_req = 1'b1; pc_load_value = 15'h0055;
        @(posedge clk); @(negedge clk);
        chk("R12", "pc after fetch with request", 32'(pc_out), 32'h1ABB);
        @(posedge clk); @(negedge clk);
        chk("R12", "pc after exec with request", 32'(pc_out), 32'h0055);
        pc_load_req = 1'b0;
        chk("R12", "fetch from loaded pc", 32'(mem_addr), 32'h0055);

        // R1: reset applied in an execute cycle.
        @(posedge clk); @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R1", "pc after mid reset", 32'(pc_out), 32'h0);
        chk("R1", "phase after mid reset", 32'(exec_phase), 32'h0);
        rst_n = 1'b1;
        chk("R1", "fetch addr after mid reset", 32'(mem_addr), 32'h0);

        // R10: strobes never overlapped during the run.
        chk("R10", "cycles with both strobes", 32'(both_strobes), 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule